// File: doc/BRIEF.md
# Platform Interrupt Router

This block gathers interrupt lines from a set of peripheral sources and delivers them to several processor contexts. Each source has a small priority value. Each context has its own enable mask over the sources, a priority threshold and a claim/complete register. Software uses a 32-bit register port to program all of this state. A gateway per source turns the raw input into a pending bit. Sources below a parameterised ID boundary are level-high, and sources at or above it are rising-edge. Each context gets one registered request line. It is high while some source that is pending and enabled for that context has a priority strictly above the context's threshold.

A handler reads its context's claim register. The read returns the ID of the best eligible source and, in the same cycle, clears that source's pending bit. The source then stays in flight until the handler writes the same ID back to the claim register. Only after that write can the gateway raise the source again. Source ID 0 does not exist, and a claim that returns 0 means nothing was available.

The register port is a valid/ready request channel. `req_ready` is held high, so every request is accepted in the cycle its `req_valid` is seen. Read data comes back on `rsp_valid`/`rsp_rdata` exactly one cycle after the read is accepted. The response cannot be stalled, so the requester must be able to take it in that cycle. Writes produce no response.

Top module: `irq_router`

## Requirements
- R1: Source ID 0 does not exist. Its priority word reads 0 whatever is written to it, its enable bit (bit 0 of each context's first enable word) reads 0, and writing 0 to a claim register has no effect.
- R2: The priority of source N is the 32-bit word at byte offset 4*N. Only bits [2:0] are stored, and the upper bits read back as 0.
- R3: The enable word of context C for sources 32*W..32*W+31 is at offset 0x2000 + C*0x80 + 4*W. Source N is bit N%32 of that word, and bits with no source behind them read 0.
- R4: The threshold of context C is at offset 0x200000 + C*0x1000, and only its bits [2:0] are stored. The claim/complete register of context C is at offset 0x200000 + C*0x1000 + 4.
- R5: Output `ctx_irq[C]` is high exactly when, one cycle earlier, some source was pending, enabled for C, and had a priority strictly greater than C's threshold. A source input that rises is sampled at the next clock edge, so the request line follows two edges after the input changes.
- R6: A threshold of 7 keeps a context's request low and makes its claims return 0. A threshold of 0 lets any source with a nonzero priority through.
- R7: A claim read returns the ID of the eligible source with the highest priority, and the lowest ID when priorities tie. It clears that source's pending bit in the same cycle. It returns 0 when no source is eligible.
- R8: A claimed source is not delivered or claimed again until its ID is written to a claim register.
- R9: A completion write is ignored unless the named source is enabled for the context that owns the written claim register.
- R10: For a level source (ID below 16 by default), completion re-pends the source if its input is high at that moment. Once a level source is pending it stays pending after its input drops, until it is claimed.
- R11: For an edge source (ID 16 and above by default), each rising edge pends the source. One rising edge seen while the source is in flight is remembered and pends it again at completion. An input held high produces no further requests.
- R12: Reads of unimplemented offsets return 0, and writes to them change no state. Unimplemented offsets are misaligned addresses, missing contexts, enable words beyond the last source, and unused words of a context page.
- R13: After reset, every priority, enable, threshold, pending and in-flight bit is 0 and every `ctx_irq` is low.
- R14: `req_ready` is always high. A read accepted on one clock edge has `rsp_valid` high with its data after that edge, for one cycle. Writes raise no `rsp_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_irq | input | NUM_SRC | Raw source inputs, bit k-1 belongs to source ID k |
| req_valid | input | 1 | Register request present |
| req_ready | output | 1 | Request accepted (always high) |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address of the register |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| ctx_irq | output | NUM_CTX | Registered interrupt request per context |

## Verification
The assertions rely on the claim path clearing only a source that is actually pending. They also rely on read requests arriving as single-cycle valid pulses with a defined `req_we`. The bench keeps to this by driving every request for exactly one cycle, changing inputs only on the falling edge, and never issuing a claim and a completion in the same cycle. Random stimulus stays on level sources, with random priorities, enables and thresholds. After each round the bench drains every pending source, so that its model of the pending state stays exact. Edge sources, ties and completions from the wrong context are covered by directed sequences.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;

  typedef enum logic [1:0] {
    RGN_NONE,
    RGN_PRIO,
    RGN_ENABLE,
    RGN_CTX
  } region_e;

  localparam logic [31:0] EN_BASE    = 32'h0000_2000;
  localparam logic [31:0] EN_STRIDE  = 32'h0000_0080;
  localparam logic [31:0] CTX_BASE   = 32'h0020_0000;
  localparam logic [31:0] CTX_STRIDE = 32'h0000_1000;
  localparam logic [31:0] CTX_THR    = 32'h0000_0000;
  localparam logic [31:0] CTX_CLAIM  = 32'h0000_0004;

endpackage

// File: rtl/src_gate.sv
module src_gate #(
  parameter bit EDGE = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  input  logic claim,
  input  logic complete,
  output logic pend
);

  logic prev_q, infl_q, seen_q, pend_q;
  logic rise, trig;

  assign rise = raw & ~prev_q;
  assign trig = EDGE ? rise : raw;
  assign pend = pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      infl_q <= 1'b0;
      seen_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      prev_q <= raw;
      if (claim) begin
        pend_q <= 1'b0;
        infl_q <= 1'b1;
        seen_q <= EDGE & rise;
      end else if (complete && infl_q) begin
        infl_q <= 1'b0;
        pend_q <= EDGE ? (seen_q | rise) : raw;
        seen_q <= 1'b0;
      end else if (!infl_q) begin
        if (trig) pend_q <= 1'b1;
      end else if (EDGE && rise) begin
        seen_q <= 1'b1;
      end
    end
  end

  // R7: a claim only lands on a pending source and clears it
  assert_claim_on_pending_R7: assert property (@(posedge clk) disable iff (!rst_n)
    claim |-> pend_q);
  assert_claim_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    claim |=> !pend_q);
  // R8: in flight without completion keeps the source from pending
  assert_inflight_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (infl_q && !complete) |=> !pend_q);

endmodule

// File: rtl/ctx_pick.sv
module ctx_pick #(
  parameter int NUM_SRC = 31,
  parameter int PRIO_W  = 3,
  parameter int ID_W    = 5
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NUM_SRC:0]              pend,
  input  logic [NUM_SRC:0]              en,
  input  logic [(NUM_SRC+1)*PRIO_W-1:0] prio_flat,
  input  logic [PRIO_W-1:0]             thr,
  output logic [ID_W-1:0]               win_id,
  output logic                          irq
);

  logic [PRIO_W-1:0] win_pri;
  logic              irq_q;

  always_comb begin
    win_id  = '0;
    win_pri = '0;
    for (int i = 1; i <= NUM_SRC; i++) begin
      if (pend[i] && en[i] && (prio_flat[i*PRIO_W +: PRIO_W] > thr) &&
          (prio_flat[i*PRIO_W +: PRIO_W] > win_pri)) begin
        win_id  = ID_W'(i);
        win_pri = prio_flat[i*PRIO_W +: PRIO_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= (win_id != '0);
  end

  assign irq = irq_q;

  // R5: request follows eligibility one cycle later
  assert_irq_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (win_id != '0) |=> irq_q);
  assert_irq_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (win_id == '0) |=> !irq_q);
  // R6: maximum threshold silences the context
  assert_thr_max_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (thr == '1) |=> !irq_q);

endmodule

// File: rtl/irq_router.sv
module irq_router
  import irq_router_pkg::*;
#(
  parameter int NUM_SRC    = 31,
  parameter int NUM_CTX    = 2,
  parameter int PRIO_W     = 3,
  parameter int ADDR_W     = 22,
  parameter int EDGE_FIRST = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_irq,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_we,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [31:0]        req_wdata,
  output logic               rsp_valid,
  output logic [31:0]        rsp_rdata,
  output logic [NUM_CTX-1:0] ctx_irq
);

  localparam int ID_W     = $clog2(NUM_SRC + 1);
  localparam int CTX_W    = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1;
  localparam int EN_WORDS = (NUM_SRC + 32) / 32;

  logic [PRIO_W-1:0]            prio_q [NUM_SRC+1];
  logic [NUM_SRC:0]             en_q   [NUM_CTX];
  logic [PRIO_W-1:0]            thr_q  [NUM_CTX];
  logic [ID_W-1:0]              best_id[NUM_CTX];
  logic [(NUM_SRC+1)*PRIO_W-1:0] prio_flat;
  logic [NUM_SRC:0]             pend, claim_v, done_v;

  region_e          rgn;
  logic [CTX_W-1:0] ctx_idx;
  logic [ID_W-1:0]  src_idx;
  int               word_idx;
  logic             is_claim;
  logic [31:0]      a_ext, off, rd_val;
  logic             acc;

  assign req_ready = 1'b1;
  assign acc       = req_valid;
  assign a_ext     = 32'(req_addr);

  // Address decode
  always_comb begin
    rgn      = RGN_NONE;
    ctx_idx  = '0;
    src_idx  = '0;
    word_idx = 0;
    is_claim = 1'b0;
    off      = '0;
    if (a_ext[1:0] == 2'b00) begin
      if (a_ext < EN_BASE) begin
        if (a_ext < 32'(4 * (NUM_SRC + 1))) begin
          rgn     = RGN_PRIO;
          src_idx = ID_W'(a_ext >> 2);
        end
      end else if (a_ext < CTX_BASE) begin
        off      = a_ext - EN_BASE;
        word_idx = int'((off % EN_STRIDE) >> 2);
        if ((off / EN_STRIDE) < 32'(NUM_CTX) && word_idx < EN_WORDS) begin
          rgn     = RGN_ENABLE;
          ctx_idx = CTX_W'(off / EN_STRIDE);
        end
      end else begin
        off = a_ext - CTX_BASE;
        if ((off / CTX_STRIDE) < 32'(NUM_CTX) &&
            ((off % CTX_STRIDE) == CTX_THR || (off % CTX_STRIDE) == CTX_CLAIM)) begin
          rgn      = RGN_CTX;
          ctx_idx  = CTX_W'(off / CTX_STRIDE);
          is_claim = ((off % CTX_STRIDE) == CTX_CLAIM);
        end
      end
    end
  end

  // Read mux
  always_comb begin
    rd_val = '0;
    case (rgn)
      RGN_PRIO:   rd_val = 32'(prio_q[src_idx]);
      RGN_ENABLE: begin
        for (int i = 0; i <= NUM_SRC; i++)
          if (i / 32 == word_idx) rd_val[i % 32] = en_q[ctx_idx][i];
      end
      RGN_CTX:    rd_val = is_claim ? 32'(best_id[ctx_idx]) : 32'(thr_q[ctx_idx]);
      default:    rd_val = '0;
    endcase
  end

  // Claim and completion strobes
  always_comb begin
    claim_v = '0;
    done_v  = '0;
    if (acc && rgn == RGN_CTX && is_claim) begin
      if (!req_we) begin
        if (best_id[ctx_idx] != '0) claim_v[best_id[ctx_idx]] = 1'b1;
      end else if (req_wdata != '0 && req_wdata <= 32'(NUM_SRC)) begin
        if (en_q[ctx_idx][req_wdata[ID_W-1:0]]) done_v[req_wdata[ID_W-1:0]] = 1'b1;
      end
    end
  end

  // Configuration registers
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i <= NUM_SRC; i++) prio_q[i] <= '0;
      for (int c = 0; c < NUM_CTX; c++) begin
        en_q[c]  <= '0;
        thr_q[c] <= '0;
      end
    end else if (acc && req_we) begin
      case (rgn)
        RGN_PRIO: if (src_idx != '0) prio_q[src_idx] <= req_wdata[PRIO_W-1:0];
        RGN_ENABLE: begin
          for (int i = 1; i <= NUM_SRC; i++)
            if (i / 32 == word_idx) en_q[ctx_idx][i] <= req_wdata[i % 32];
        end
        RGN_CTX: if (!is_claim) thr_q[ctx_idx] <= req_wdata[PRIO_W-1:0];
        default: ;
      endcase
    end
  end

  // Read response
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= acc && !req_we;
      if (acc && !req_we) rsp_rdata <= rd_val;
    end
  end

  // Source gateways
  assign pend[0] = 1'b0;
  generate
    for (genvar s = 1; s <= NUM_SRC; s++) begin : g_gate
      src_gate #(.EDGE(s >= EDGE_FIRST)) u_gate (
        .clk     (clk),
        .rst_n   (rst_n),
        .raw     (src_irq[s-1]),
        .claim   (claim_v[s]),
        .complete(done_v[s]),
        .pend    (pend[s])
      );
    end
    for (genvar s = 0; s <= NUM_SRC; s++) begin : g_flat
      assign prio_flat[s*PRIO_W +: PRIO_W] = prio_q[s];
    end
    for (genvar c = 0; c < NUM_CTX; c++) begin : g_ctx
      ctx_pick #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .ID_W(ID_W)) u_pick (
        .clk      (clk),
        .rst_n    (rst_n),
        .pend     (pend),
        .en       (en_q[c]),
        .prio_flat(prio_flat),
        .thr      (thr_q[c]),
        .win_id   (best_id[c]),
        .irq      (ctx_irq[c])
      );
    end
  endgenerate

  // R14: every accepted read is answered on the next cycle
  assert_read_answered_R14: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_we) |=> rsp_valid);
  assert_write_silent_R14: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && !req_we) |=> !rsp_valid);

endmodule

// File: tb/irq_router_tb_top.sv
module irq_router_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [30:0] src_irq = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_we = 1'b0;
  logic [21:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic [1:0]  ctx_irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done_flag = 1'b0;
  logic last_rv;

  int          m_prio [32];
  logic [31:0] m_en;
  int          m_thr;

  always #5 clk = ~clk;

  irq_router dut_i (
    .clk(clk), .rst_n(rst_n), .src_irq(src_irq),
    .req_valid(req_valid), .req_ready(req_ready), .req_we(req_we),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .ctx_irq(ctx_irq)
  );

  function automatic logic [21:0] a_prio(int n);   return 22'(4 * n); endfunction
  function automatic logic [21:0] a_en(int c);     return 22'(32'h2000 + c * 32'h80); endfunction
  function automatic logic [21:0] a_thr(int c);    return 22'(32'h200000 + c * 32'h1000); endfunction
  function automatic logic [21:0] a_clm(int c);    return 22'(32'h200004 + c * 32'h1000); endfunction

  function automatic int model_best(logic [31:0] pn);
    int id = 0;
    int bp = 0;
    for (int i = 1; i < 32; i++)
      if (pn[i] && m_en[i] && m_prio[i] > m_thr && m_prio[i] > bp) begin
        id = i;
        bp = m_prio[i];
      end
    return id;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [21:0] a, logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_we = 1'b1; req_addr = a; req_wdata = d;
    @(posedge clk); #1;
    req_valid = 1'b0; req_we = 1'b0;
  endtask

  task automatic rd(logic [21:0] a, output logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_we = 1'b0; req_addr = a;
    @(posedge clk); #1;
    d = rsp_rdata; last_rv = rsp_valid;
    req_valid = 1'b0;
  endtask

  task automatic set_src(logic [30:0] v);
    @(negedge clk);
    src_irq = v;
    @(posedge clk); #1;
  endtask

  task automatic settle();
    @(posedge clk); #1;
    @(posedge clk); #1;
  endtask

  task automatic drain();
    logic [31:0] id;
    wr(a_thr(0), 0);
    wr(a_en(0), 32'hFFFF_FFFE);
    for (int s = 1; s < 32; s++) wr(a_prio(s), 1);
    for (int k = 0; k < 40; k++) begin
      rd(a_clm(0), id);
      if (id == 0) break;
      wr(a_clm(0), id);
    end
  endtask

  initial begin
    #(200000 * 10);
    if (!done_flag) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;

    // R13 reset state
    chk("R13 irq after reset", 32'(ctx_irq), 0);
    rd(a_prio(1), v);  chk("R13 prio reset", v, 0);
    chk("R14 rsp_valid on read", 32'(last_rv), 1);
    chk("R14 ready high", 32'(req_ready), 1);
    rd(a_clm(0), v);   chk("R7 empty claim", v, 0);

    // R2 / R1 priority map
    wr(a_prio(5), 32'hFF); rd(a_prio(5), v); chk("R2 prio low bits", v, 7);
    wr(a_prio(0), 5);      rd(a_prio(0), v); chk("R1 prio id0", v, 0);

    // R3 / R12 enable map
    wr(a_en(1), 32'hFFFF_FFFF); rd(a_en(1), v); chk("R3 enable word", v, 32'hFFFF_FFFE);
    rd(a_en(1) + 4, v);          chk("R12 enable word beyond", v, 0);
    wr(22'h1000, 32'h5); rd(22'h1000, v); chk("R12 gap read", v, 0);
    wr(a_en(2), 32'hFFFF); rd(a_en(2), v); chk("R12 missing ctx", v, 0);
    wr(a_prio(5) + 1, 0); rd(a_prio(5), v); chk("R12 misaligned write ignored", v, 7);

    // R4 threshold
    wr(a_thr(0), 32'hFA); rd(a_thr(0), v); chk("R4 threshold bits", v, 2);
    wr(a_thr(0), 0);

    // R5 timing
    wr(a_en(0), 32'h0C); wr(a_prio(2), 3); wr(a_prio(3), 3);
    @(negedge clk); src_irq[1] = 1'b1;
    @(posedge clk); #1; chk("R5 one edge after input", 32'(ctx_irq[0]), 0);
    @(posedge clk); #1; chk("R5 two edges after input", 32'(ctx_irq[0]), 1);
    chk("R5 ctx1 also delivered", 32'(ctx_irq[1]), 1);
    wr(a_en(1), 0); settle(); chk("R5 ctx1 disabled", 32'(ctx_irq[1]), 0);

    // R6 threshold behaviour
    wr(a_thr(0), 7); settle(); chk("R6 thr 7 blocks", 32'(ctx_irq[0]), 0);
    rd(a_clm(0), v); chk("R6 thr 7 claim", v, 0);
    wr(a_thr(0), 3); settle(); chk("R5 strict greater", 32'(ctx_irq[0]), 0);
    wr(a_thr(0), 0); settle(); chk("R6 thr 0 passes", 32'(ctx_irq[0]), 1);

    // R7 tie / R8 in flight
    set_src(31'b110);
    rd(a_clm(0), v); chk("R7 tie lowest id", v, 2);
    rd(a_clm(0), v); chk("R8 next claim", v, 3);
    rd(a_clm(0), v); chk("R8 both in flight", v, 0);
    settle(); chk("R8 no request in flight", 32'(ctx_irq[0]), 0);

    // R9 / R10 / R1 completion
    wr(a_clm(1), 2); rd(a_clm(0), v); chk("R9 disabled ctx complete", v, 0);
    wr(a_clm(0), 0); rd(a_clm(0), v); chk("R1 id0 complete", v, 0);
    wr(a_clm(0), 2); rd(a_clm(0), v); chk("R10 level re-pend", v, 2);
    wr(a_clm(0), 3);
    set_src('0);
    wr(a_clm(0), 2);
    rd(a_clm(0), v); chk("R10 pending held after drop", v, 3);
    wr(a_clm(0), 3); rd(a_clm(0), v); chk("R10 no re-pend when low", v, 0);

    // R11 edge source 20
    wr(a_prio(20), 4); wr(a_en(0), 32'h0010_0000);
    @(negedge clk); src_irq[19] = 1'b1; @(negedge clk); src_irq[19] = 1'b0;
    rd(a_clm(0), v); chk("R11 edge claim", v, 20);
    @(negedge clk); src_irq[19] = 1'b1; @(negedge clk); src_irq[19] = 1'b0;
    rd(a_clm(0), v); chk("R11 edge in flight", v, 0);
    wr(a_clm(0), 20); rd(a_clm(0), v); chk("R11 remembered edge", v, 20);
    wr(a_clm(0), 20); rd(a_clm(0), v); chk("R11 single memory", v, 0);
    set_src(31'h0008_0000);
    rd(a_clm(0), v); chk("R11 held high claim", v, 20);
    wr(a_clm(0), 20); rd(a_clm(0), v); chk("R11 held high no repeat", v, 0);
    set_src('0);

    // Random level rounds
    drain();
    for (int it = 0; it < 40; it++) begin
      logic [31:0] lv;
      int exp_id;
      lv   = $urandom & 32'h0000_FFFE;
      m_en = $urandom & 32'h0000_FFFE;
      m_thr = int'($urandom % 7);
      for (int s = 0; s < 32; s++) m_prio[s] = 0;
      for (int s = 1; s < 16; s++) begin
        m_prio[s] = int'($urandom % 8);
        wr(a_prio(s), 32'(m_prio[s]));
      end
      for (int s = 16; s < 32; s++) wr(a_prio(s), 0);
      wr(a_thr(0), 32'(m_thr));
      wr(a_en(0), m_en);
      set_src(lv[31:1]);
      settle();
      exp_id = model_best(lv);
      chk("R5 random request", 32'(ctx_irq[0]), 32'(exp_id != 0));
      rd(a_clm(0), v); chk("R7 random claim", v, 32'(exp_id));
      if (exp_id != 0) begin
        wr(a_clm(0), 32'(exp_id));
        rd(a_clm(0), v); chk("R10 random re-pend", v, 32'(exp_id));
        wr(a_clm(0), 32'(exp_id));
      end
      set_src('0);
      drain();
    end

    done_flag = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule